// File: doc/BRIEF.md
# Trigger-Gated Offset Stage

This block sits in a sample-rate signal path, between a signed 14-bit sample stream and the node that sums streams ahead of a DAC. It watches a trigger input for a rising edge. After the edge it counts a programmable number of clocks. It then opens a gate for a second programmable number of clocks. A sample accepted while the gate is open leaves the block with a programmable signed offset added, saturated to the 14-bit range. All other samples leave unchanged. The output is registered, so every sample comes out one clock after it is accepted.

Samples enter and leave through valid/ready handshakes. A sample moves across an interface on a clock edge where both valid and ready are high. The input is ready whenever the output register is empty, or when the downstream side takes the held sample in that same cycle. While the output is valid and its ready is low, the output data holds and no new sample is taken.

The gate timing counts clocks, not transferred samples, so back-pressure does not stretch the window. A processor sets the delay, the width, the offset and an enable bit over a small memory-mapped bus. The same bus reads back those settings and a gate-active status bit.

Top module: `gated_offset_stage`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all four settings read as zero, `m_valid_o` is 0 and `bus_ack_o` is 0.
- R2: Only the low 20 bits of `bus_addr_i` are decoded, and a write lands when `bus_wen_i` is high. The settings sit at these offsets:
  - 0x100: delay in clocks (32 bits).
  - 0x104: gate width in clocks (32 bits).
  - 0x108: offset, a 14-bit two's-complement value in bits 13:0, read back sign-extended to 32 bits.
  - 0x10C: enable in bit 0.
- R3: `bus_ack_o` is high in exactly the cycle after each cycle in which `bus_wen_i` or `bus_ren_i` is high. `bus_err_o` is always 0. Read data appears with the ack; `bus_rdata_o` is zero in every cycle that does not answer a read.
- R4: A read of an offset that maps to no register returns zero and is still acknowledged.
- R5: The trigger is edge-sensitive: a trigger held high starts only one sequence. Call the clock edge that samples a rising trigger (with enable set and the sequencer idle) clock 0. Then, with delay D, the gate is open in the cycles that follow clocks D through D+W-1.
- R6: The gate stays open for exactly W clocks. A width of zero opens it in no cycle.
- R7: A rising trigger edge that arrives while a sequence is in its delay or open phase is ignored. It neither restarts nor extends the sequence.
- R8: When the enable bit is 0, no sample is modified, the sequence in progress is abandoned and triggers are ignored.
- R9: The sum of a sample and the offset is saturated. A sum above 8191 gives 8191, and a sum below -8192 gives -8192.
- R10: Each accepted sample appears on `m_data_o` one clock later. It is unchanged when the gate was closed in its acceptance cycle, and offset-added when the gate was open.
- R11: `s_ready_o` equals (not `m_valid_o`) or `m_ready_i`. While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` and `m_data_o` hold their values.
- R12: Bit 0 of the read value at offset 0x110 is 1 exactly when the gate is open in the cycle of the read. The other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Trigger; its rising edge starts a sequence |
| s_valid_i | input | 1 | Input sample valid |
| s_ready_o | output | 1 | Input sample ready |
| s_data_i | input | 14 | Input sample, two's complement |
| m_valid_o | output | 1 | Output sample valid |
| m_ready_i | input | 1 | Output sample ready |
| m_data_o | output | 14 | Output sample, two's complement |
| bus_addr_i | input | 32 | Register bus address |
| bus_wdata_i | input | 32 | Register bus write data |
| bus_wen_i | input | 1 | Register bus write enable |
| bus_ren_i | input | 1 | Register bus read enable |
| bus_rdata_o | output | 32 | Register bus read data |
| bus_ack_o | output | 1 | Access acknowledge |
| bus_err_o | output | 1 | Access error, always 0 |

## Verification
The assertions check the local rules on every cycle:
- the ack follows each access by one clock;
- unmapped reads return zero;
- a stalled output holds;
- a closed-gate sample passes through untouched;
- a saturated sum never flips the sign of a same-sign operand;
- the open phase never holds a zero count;
- a busy sequence keeps counting down through a new trigger edge;
- clearing the enable returns the sequencer to idle.

Only the bench scenarios can show where the window falls relative to the trigger edge and how many cycles it lasts. They also cover zero delay and zero width, held triggers and retriggers, saturation at both rails, and the timing of the status bit. The bench covers all of these, under steady flow and under random back-pressure, with a reference model compared on every clock.

// File: rtl/gos_pkg.sv
package gos_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_OPEN = 2'd2
  } phase_t;

  localparam logic [19:0] OFS_DELAY  = 20'h00100;
  localparam logic [19:0] OFS_WIDTH  = 20'h00104;
  localparam logic [19:0] OFS_OFFSET = 20'h00108;
  localparam logic [19:0] OFS_CTRL   = 20'h0010C;
  localparam logic [19:0] OFS_STATUS = 20'h00110;
endpackage

// File: rtl/gos_regs.sv
module gos_regs
  import gos_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DEC_W = 20,
  parameter int CNT_W = 32,
  parameter int SMP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             wen_i,
  input  logic             ren_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             ack_o,
  input  logic             gate_i,
  output logic [CNT_W-1:0] delay_o,
  output logic [CNT_W-1:0] width_o,
  output logic [SMP_W-1:0] offset_o,
  output logic             enable_o
);
  logic [DEC_W-1:0] ofs;
  logic [BUS_W-1:0] rd_val;
  logic             mapped;
  logic             unused_addr;

  assign ofs         = addr_i[DEC_W-1:0];
  assign unused_addr = ^addr_i[BUS_W-1:DEC_W];

  always_comb begin
    rd_val = '0;
    mapped = 1'b1;
    case (ofs)
      DEC_W'(OFS_DELAY):  rd_val = BUS_W'(delay_o);
      DEC_W'(OFS_WIDTH):  rd_val = BUS_W'(width_o);
      DEC_W'(OFS_OFFSET): rd_val = {{(BUS_W-SMP_W){offset_o[SMP_W-1]}}, offset_o};
      DEC_W'(OFS_CTRL):   rd_val = {{(BUS_W-1){1'b0}}, enable_o};
      DEC_W'(OFS_STATUS): rd_val = {{(BUS_W-1){1'b0}}, gate_i};
      default:            mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_o  <= '0;
      width_o  <= '0;
      offset_o <= '0;
      enable_o <= 1'b0;
      ack_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ack_o   <= wen_i | ren_i;
      rdata_o <= ren_i ? rd_val : '0;
      if (wen_i) begin
        case (ofs)
          DEC_W'(OFS_DELAY):  delay_o  <= wdata_i[CNT_W-1:0];
          DEC_W'(OFS_WIDTH):  width_o  <= wdata_i[CNT_W-1:0];
          DEC_W'(OFS_OFFSET): offset_o <= wdata_i[SMP_W-1:0];
          DEC_W'(OFS_CTRL):   enable_o <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assert_ack_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i || ren_i) |=> ack_o);
  assert_no_spurious_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen_i || ren_i) |=> !ack_o);
  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_i && !mapped) |=> (ack_o && rdata_o == '0));
endmodule

// File: rtl/gos_window.sv
module gos_window
  import gos_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             gate_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             trig_q;
  logic             trig_edge;

  assign trig_edge = trig_i & ~trig_q;
  assign gate_o    = (phase == PH_OPEN) && en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (!en_i) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (trig_edge) begin
              if (delay_i != '0) begin
                phase <= PH_WAIT;
                cnt   <= delay_i;
              end else if (width_i != '0) begin
                phase <= PH_OPEN;
                cnt   <= width_i;
              end
            end
          end
          PH_WAIT: begin
            if (cnt == ONE) begin
              if (width_i != '0) begin
                phase <= PH_OPEN;
                cnt   <= width_i;
              end else begin
                phase <= PH_IDLE;
                cnt   <= '0;
              end
            end else begin
              cnt <= cnt - ONE;
            end
          end
          PH_OPEN: begin
            if (cnt == ONE) begin
              phase <= PH_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          default: begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assert_open_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPEN) |-> (cnt != '0));
  assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (phase == PH_IDLE));
  assert_wait_ignores_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && cnt > ONE && en_i) |=> (phase == PH_WAIT && cnt == $past(cnt) - ONE));
  assert_open_ignores_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPEN && cnt > ONE && en_i) |=> (phase == PH_OPEN && cnt == $past(cnt) - ONE));
  assert_edge_starts_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && en_i && trig_edge && delay_i != '0) |=> (phase == PH_WAIT));
endmodule

// File: rtl/gos_datapath.sv
module gos_datapath #(
  parameter int SMP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [SMP_W-1:0] s_data_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [SMP_W-1:0] m_data_o,
  input  logic             gate_i,
  input  logic [SMP_W-1:0] offset_i
);
  localparam int               SUM_W = SMP_W + 1;
  localparam logic [SMP_W-1:0] MAXV  = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] MINV  = {1'b1, {(SMP_W-1){1'b0}}};

  logic [SUM_W-1:0] sum_w;
  logic [SMP_W-1:0] sat_w;
  logic [SMP_W-1:0] next_w;

  assign sum_w = {s_data_i[SMP_W-1], s_data_i} + {offset_i[SMP_W-1], offset_i};

  always_comb begin
    if (sum_w[SUM_W-1] != sum_w[SUM_W-2]) begin
      sat_w = sum_w[SUM_W-1] ? MINV : MAXV;
    end else begin
      sat_w = sum_w[SMP_W-1:0];
    end
  end

  assign next_w    = gate_i ? sat_w : s_data_i;
  assign s_ready_o = !m_valid_o || m_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (s_ready_o) begin
      m_valid_o <= s_valid_i;
      if (s_valid_i) begin
        m_data_o <= next_w;
      end
    end
  end

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));
  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o && !gate_i) |=> (m_valid_o && m_data_o == $past(s_data_i)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o && gate_i && s_data_i[SMP_W-1] == offset_i[SMP_W-1])
    |=> (m_data_o[SMP_W-1] == $past(s_data_i[SMP_W-1])));
endmodule

// File: rtl/gated_offset_stage.sv
module gated_offset_stage #(
  parameter int SMP_W = 14,
  parameter int BUS_W = 32,
  parameter int DEC_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [SMP_W-1:0] s_data_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [SMP_W-1:0] m_data_o,
  input  logic [BUS_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  input  logic             bus_wen_i,
  input  logic             bus_ren_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             bus_ack_o,
  output logic             bus_err_o
);
  logic [CNT_W-1:0] delay_w;
  logic [CNT_W-1:0] width_w;
  logic [SMP_W-1:0] offset_w;
  logic             enable_w;
  logic             gate_w;

  assign bus_err_o = 1'b0;

  gos_regs #(
    .BUS_W(BUS_W), .DEC_W(DEC_W), .CNT_W(CNT_W), .SMP_W(SMP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .wen_i(bus_wen_i), .ren_i(bus_ren_i),
    .rdata_o(bus_rdata_o), .ack_o(bus_ack_o),
    .gate_i(gate_w),
    .delay_o(delay_w), .width_o(width_w),
    .offset_o(offset_w), .enable_o(enable_w)
  );

  gos_window #(
    .CNT_W(CNT_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n),
    .trig_i(trig_i), .en_i(enable_w),
    .delay_i(delay_w), .width_i(width_w),
    .gate_o(gate_w)
  );

  gos_datapath #(
    .SMP_W(SMP_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .gate_i(gate_w), .offset_i(offset_w)
  );
endmodule

// File: tb/gated_offset_stage_test.sv
module gated_offset_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [13:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [13:0] m_data;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic        ren = 1'b0;
  logic [31:0] rdata;
  logic        ack;
  logic        err;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    bp_mode = 1'b0;
  int    hit_cnt = 0;
  int    hit_val = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  gated_offset_stage uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wen_i(wen), .bus_ren_i(ren),
    .bus_rdata_o(rdata), .bus_ack_o(ack), .bus_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat14(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  // behavioural reference state
  int          cyc = 0;
  int          win_start = -1000;
  int          win_w = 0;
  int          busy_last = -1000;
  bit          en_m = 0;
  logic [31:0] delay_m = 0;
  logic [31:0] width_m = 0;
  int          off_m = 0;
  bit          trig_prev = 0;
  bit          mv_m = 0;
  int          md_m = 0;
  bit          ack_m = 0;
  logic [31:0] rd_m = 0;
  bit          gate_prev = 0;

  always @(posedge clk) begin
    bit          acc_ready;
    logic [31:0] rv;
    logic signed [13:0] t14;
    int          sd;
    cyc++;
    if (!rst_n) begin
      win_start = -1000; win_w = 0; busy_last = -1000; en_m = 0;
      delay_m = 0; width_m = 0; off_m = 0; trig_prev = 0;
      mv_m = 0; md_m = 0; ack_m = 0; rd_m = 0; gate_prev = 0;
    end else begin
      acc_ready = !mv_m || m_ready;
      if (acc_ready) begin
        mv_m = s_valid;
        if (s_valid) begin
          t14 = s_data;
          sd = t14;
          md_m = gate_prev ? sat14(sd + off_m) : sd;
        end
      end
      ack_m = wen || ren;
      rv = 0;
      case (addr[19:0])
        20'h00100: rv = delay_m;
        20'h00104: rv = width_m;
        20'h00108: rv = off_m;
        20'h0010C: rv = {31'b0, en_m};
        20'h00110: rv = {31'b0, gate_prev};
        default:   rv = 0;
      endcase
      rd_m = ren ? rv : 0;
      if (!en_m) begin
        win_start = -1000; win_w = 0; busy_last = -1000;
      end else if (trig && !trig_prev && (cyc - 1 > busy_last)) begin
        win_start = cyc + int'(delay_m);
        win_w = int'(width_m);
        busy_last = cyc + int'(delay_m) + int'(width_m) - 1;
      end
      trig_prev = trig;
      if (wen) begin
        case (wdata[19:0] == 0 ? addr[19:0] : addr[19:0])
          20'h00100: delay_m = wdata;
          20'h00104: width_m = wdata;
          20'h00108: begin t14 = wdata[13:0]; off_m = t14; end
          20'h0010C: en_m = wdata[0];
          default: ;
        endcase
      end
      gate_prev = en_m && (cyc >= win_start) && (cyc < win_start + win_w);
    end
    #5;
    chk(m_valid == mv_m, cur_req, m_valid, mv_m);
    if (mv_m) chk(m_data == md_m[13:0], cur_req, $signed(m_data), md_m);
    chk(ack == ack_m, "R3", ack, ack_m);
    chk(rdata == rd_m, cur_req, rdata, rd_m);
    chk(err == 1'b0, "R3", err, 0);
    chk(s_ready == (!m_valid || m_ready), "R11", s_ready, !m_valid || m_ready);
    if (m_valid && m_ready && $signed(m_data) == hit_val) hit_cnt++;
  end

  always @(negedge clk) begin
    if (bp_mode) m_ready <= ($urandom % 3) != 0;
    else m_ready <= 1'b1;
  end

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; ren = 1'b1;
    @(negedge clk); ren = 1'b0; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int d, input int w, input int off, input int value);
    bus_wr(32'h100, d);
    bus_wr(32'h104, w);
    bus_wr(32'h108, off);
    @(negedge clk); s_data = value[13:0]; s_valid = 1'b1;
    idle(4);
    hit_cnt = 0;
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    chk(m_valid == 1'b0, "R1", m_valid, 0);
    chk(ack == 1'b0, "R1", ack, 0);
    rst_n = 1'b1;
    idle(2);
    bus_rd(32'h100, v); chk(v == 0, "R1", v, 0);
    bus_rd(32'h104, v); chk(v == 0, "R1", v, 0);
    bus_rd(32'h108, v); chk(v == 0, "R1", v, 0);
    bus_rd(32'h10C, v); chk(v == 0, "R1", v, 0);

    cur_req = "R2";
    bus_wr(32'hFFF00100, 32'h0000_1234);
    bus_rd(32'h0000_0100, v); chk(v == 32'h1234, "R2", v, 32'h1234);
    bus_wr(32'h104, 32'h0000_0007);
    bus_rd(32'h00A00104, v); chk(v == 7, "R2", v, 7);
    bus_wr(32'h108, 32'h0000_3FFF);
    bus_rd(32'h108, v); chk(v == 32'hFFFF_FFFF, "R2", v, 32'hFFFF_FFFF);
    bus_wr(32'h10C, 32'h0000_0001);
    bus_rd(32'h10C, v); chk(v == 1, "R2", v, 1);
    bus_wr(32'h10C, 32'h0000_0000);

    cur_req = "R4";
    bus_rd(32'h200, v); chk(v == 0, "R4", v, 0);
    bus_rd(32'h114, v); chk(v == 0, "R4", v, 0);

    cur_req = "R8";
    hit_val = 1100;
    setup(1, 4, 100, 1000);
    pulse(); idle(10);
    chk(hit_cnt == 0, "R8", hit_cnt, 0);

    cur_req = "R5";
    bus_wr(32'h10C, 1);
    setup(3, 4, 100, 1000);
    pulse(); idle(12);
    chk(hit_cnt == 4, "R5", hit_cnt, 4);

    cur_req = "R6";
    setup(0, 2, 100, 1000);
    pulse(); idle(8);
    chk(hit_cnt == 2, "R6", hit_cnt, 2);
    setup(5, 0, 100, 1000);
    pulse(); idle(10);
    chk(hit_cnt == 0, "R6", hit_cnt, 0);

    cur_req = "R7";
    setup(2, 6, 100, 1000);
    pulse(); idle(2); pulse(); idle(14);
    chk(hit_cnt == 6, "R7", hit_cnt, 6);
    cur_req = "R5";
    setup(1, 3, 100, 1000);
    @(negedge clk); trig = 1'b1; idle(20); trig = 1'b0; idle(4);
    chk(hit_cnt == 3, "R5", hit_cnt, 3);

    cur_req = "R9";
    hit_val = 8191;
    setup(1, 5, 8191, 8000);
    pulse(); idle(10);
    chk(hit_cnt == 5, "R9", hit_cnt, 5);
    hit_val = -8192;
    setup(0, 4, 32'h2000, -5000);
    pulse(); idle(10);
    chk(hit_cnt == 4, "R9", hit_cnt, 4);

    cur_req = "R10";
    hit_val = -4900;
    setup(2, 3, 100, -5000);
    idle(6);
    chk(hit_cnt == 0, "R10", hit_cnt, 0);

    cur_req = "R12";
    setup(0, 40, 10, 200);
    pulse(); idle(2);
    bus_rd(32'h110, v); chk(v == 1, "R12", v, 1);
    cur_req = "R8";
    bus_wr(32'h10C, 0);
    bus_rd(32'h110, v); chk(v == 0, "R8", v, 0);
    bus_wr(32'h10C, 1);
    idle(45);
    cur_req = "R12";
    bus_rd(32'h110, v); chk(v == 0, "R12", v, 0);

    cur_req = "R11";
    bp_mode = 1'b1;
    for (int k = 0; k < 40; k++) begin
      setup(k % 4, 1 + (k % 5), (k * 37) % 300, (k * 211) % 4000);
      pulse(); idle(8);
      @(negedge clk); s_valid = 1'b0; idle(2);
    end
    bp_mode = 1'b0;
    idle(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule